// File: doc/BRIEF.md
# Low-Memory Hole Remap Translator

This block maps a page number, as seen by the memory system, onto the physical page that actually holds the data. The platform leaves a hole in the address map just under the 4 GiB line. The DRAM that would sit behind that hole is moved above the line, into a window that software sets up. Three 16-bit configuration values describe the layout, and each is written through a small register-write port:

- the top of low memory;
- the base of the remap window;
- the limit of the remap window.

Each cycle the block may receive one page number, qualified by a valid strobe. One cycle later it returns one of three results, together with a flag:

- **Unchanged page.** The page is outside every remapped region and comes back as it went in.
- **Relocated page.** The page is moved into the remap window.
- **Fallback page.** The relocation would land at or beyond the window limit. The block returns a fixed fallback page and raises the out-of-range flag.

A typical user is an error-logging or scrub engine. Such an engine holds a logged DRAM page and must name the physical page behind it.

Top module: `lmr_remap_top`

## Requirements
- R1: While reset is asserted, `outValid`, `outRange` and `outPage` are zero. All three configuration values are also zero, so with no writes after reset every translated page falls back to 0xFFFFFFFF with the flag raised.
- R2: A write with `cfgWrEn` high loads `cfgData` into one configuration value, chosen by `cfgSel`:
  - 0 selects top of low memory;
  - 1 selects remap base;
  - 2 selects remap limit;
  - 3 changes nothing.

  A written value first affects a page presented in the cycle after the write. A page presented in the same cycle as the write uses the old value.
- R3: Top of low memory in pages is its register shifted left by 4. Any page strictly below it is returned unchanged with `outRange` low.
- R4: A page at or above 0x100000 and strictly below the remap base in pages (register shifted left by 14) is returned unchanged with `outRange` low.
- R5: Any other page is relocated to page − top + base, computed without wrap-around. If that result is strictly below the remap limit in pages (register shifted left by 14), it is returned with `outRange` low.
- R6: When the relocated result is not below the limit, the output is (top − 1) modulo 2^PAGE_W and `outRange` is high.
- R7: `outValid` is high in exactly the cycle after a cycle with `inValid` high. Results appear on that same edge.
- R8: After a cycle without `inValid`, `outRange` is low and `outPage` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Selects the configuration value to write (0 top, 1 base, 2 limit, 3 none) |
| cfgData | input | REG_W (16) | Value written |
| inValid | input | 1 | Page input qualifier |
| inPage | input | PAGE_W (32) | Page number to translate |
| outValid | output | 1 | Result qualifier, one cycle after `inValid` |
| outPage | output | PAGE_W (32) | Translated page |
| outRange | output | 1 | Relocation exceeded the remap limit; `outPage` is the fallback |

## Verification
The hardest case to reach from the ports is the region between the 4 GiB line and the remap base. It only exists when the base is programmed above 0x100000 pages, and a page there must pass through even though it lies above the top of low memory. The same difficulty applies to the boundary pages on each side of every threshold.

The stimulus reprograms the three values into several layouts:
- base below the line, at the line and above it;
- top of zero;
- the largest base.

For each layout it presents the exact edge pages (top − 1, top, the line, base − 1, base, and the page whose relocation equals limit − 1 or limit). Random pages, idle cycles and writes issued in the same cycle as a translation follow the directed layouts.

// File: rtl/lmr_pkg.sv
package lmr_pkg;

  typedef enum logic [1:0] {
    SEL_TOP   = 2'd0,
    SEL_BASE  = 2'd1,
    SEL_LIMIT = 2'd2,
    SEL_NONE  = 2'd3
  } cfgSel_e;

  localparam int NUM_CFG = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_CFG-1:0] load;    // [0] top, [1] base, [2] limit
    logic               capture; // a page is presented this cycle
  } ctrlStrobe_t;

endpackage

// File: rtl/lmr_ctrl.sv
module lmr_ctrl
  import lmr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [1:0]  cfgSel,
  input  logic        inValid,
  output ctrlStrobe_t strobe,
  output logic        validQ
);

  cfgSel_e selDec;
  assign selDec = cfgSel_e'(cfgSel);

  always_comb begin
    strobe = '0;
    strobe.capture = inValid;
    if (cfgWrEn) begin
      unique case (selDec)
        SEL_TOP:   strobe.load[0] = 1'b1;
        SEL_BASE:  strobe.load[1] = 1'b1;
        SEL_LIMIT: strobe.load[2] = 1'b1;
        default:   strobe.load    = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= inValid;
  end

  // R7: result qualifier follows the input strobe by one cycle
  a_r7_valid_latency: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> validQ);
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !validQ);
  // R2: the unused select never loads anything
  a_r2_sel_none: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSel == 2'd3) |-> (strobe.load == '0));
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.load));

endmodule

// File: rtl/lmr_datapath.sv
module lmr_datapath
  import lmr_pkg::*;
#(
  parameter int REG_W       = 16,
  parameter int PAGE_W      = 32,
  parameter int TOP_SHIFT   = 4,
  parameter int REMAP_SHIFT = 14,
  parameter int LINE_PAGE   = 32'h0010_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [REG_W-1:0]  cfgData,
  input  logic [PAGE_W-1:0] inPage,
  output logic [PAGE_W-1:0] outPage,
  output logic              outRange
);

  localparam int WIDE_REG = REG_W + REMAP_SHIFT;
  localparam int CALC_W   = ((PAGE_W > WIDE_REG) ? PAGE_W : WIDE_REG) + 1;

  logic [REG_W-1:0] cfgReg [NUM_CFG];

  // one holding register per configuration value
  for (genvar g = 0; g < NUM_CFG; g++) begin : gCfg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              cfgReg[g] <= '0;
      else if (strobe.load[g]) cfgReg[g] <= cfgData;
    end
    // R2: a value changes only when its own strobe fired
    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.load[g] |=> $stable(cfgReg[g]));
  end

  logic [CALC_W-1:0] topPages, basePages, limitPages, pageW, linePage;
  logic [CALC_W-1:0] relocPage, fallbackW;
  logic              belowTop, inHighGap, passThru, relocOk, errNow;
  logic [PAGE_W-1:0] resultPage;

  assign topPages   = CALC_W'(cfgReg[0]) << TOP_SHIFT;
  assign basePages  = CALC_W'(cfgReg[1]) << REMAP_SHIFT;
  assign limitPages = CALC_W'(cfgReg[2]) << REMAP_SHIFT;
  assign pageW      = CALC_W'(inPage);
  assign linePage   = CALC_W'(LINE_PAGE);

  always_comb begin
    belowTop   = pageW < topPages;
    inHighGap  = (pageW >= linePage) && (pageW < basePages);
    passThru   = belowTop || inHighGap;
    relocPage  = pageW - topPages + basePages;
    relocOk    = relocPage < limitPages;
    fallbackW  = topPages - CALC_W'(1);
    errNow     = !passThru && !relocOk;
    if (passThru)     resultPage = inPage;
    else if (relocOk) resultPage = relocPage[PAGE_W-1:0];
    else              resultPage = fallbackW[PAGE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outPage  <= '0;
      outRange <= 1'b0;
    end else begin
      outRange <= strobe.capture && errNow;
      if (strobe.capture) outPage <= resultPage;
    end
  end

  // R3: a page under the top of low memory comes back unchanged
  a_r3_low_pass: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && (pageW < topPages)) |=> (outPage == $past(inPage)) && !outRange);
  // R8: idle cycles clear the flag and hold the page
  a_r8_idle_clear: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> !outRange && $stable(outPage));

endmodule

// File: rtl/lmr_remap_top.sv
module lmr_remap_top
  import lmr_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int PAGE_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [REG_W-1:0]  cfgData,
  input  logic              inValid,
  input  logic [PAGE_W-1:0] inPage,
  output logic              outValid,
  output logic [PAGE_W-1:0] outPage,
  output logic              outRange
);

  ctrlStrobe_t strobe;

  lmr_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWrEn (cfgWrEn),
    .cfgSel  (cfgSel),
    .inValid (inValid),
    .strobe  (strobe),
    .validQ  (outValid)
  );

  lmr_datapath #(
    .REG_W  (REG_W),
    .PAGE_W (PAGE_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cfgData  (cfgData),
    .inPage   (inPage),
    .outPage  (outPage),
    .outRange (outRange)
  );

  // R6: the flag only accompanies a real result
  a_r6_flag_qualified: assert property (@(posedge clk) disable iff (!rstN)
    outRange |-> outValid);

endmodule

// File: tb/lmr_remap_top_test.sv
module lmr_remap_top_test;

  localparam int PAGE_W = 32;
  localparam longint MASK = 64'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgSel = 2'd0;
  logic [15:0] cfgData = 16'd0;
  logic        inValid = 1'b0;
  logic [31:0] inPage = 32'd0;
  logic        outValid;
  logic [31:0] outPage;
  logic        outRange;

  int checks = 0;
  int fails  = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lmr_remap_top uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgData(cfgData), .inValid(inValid), .inPage(inPage),
    .outValid(outValid), .outPage(outPage), .outRange(outRange)
  );

  // behavioural reference model
  longint mTop = 0, mBase = 0, mLimit = 0;
  longint expPage = 0;
  bit     expValid = 0, expRange = 0;
  int     expCat = 1;

  always @(posedge clk) begin
    longint p, topP, baseP, limP, rel;
    started = 1'b1;
    if (!rstN) begin
      mTop = 0; mBase = 0; mLimit = 0;
      expPage = 0; expValid = 0; expRange = 0; expCat = 1;
    end else begin
      topP = mTop * 16;
      baseP = mBase * 16384;
      limP = mLimit * 16384;
      p = longint'(inPage);
      expValid = inValid;
      expRange = 0;
      if (!inValid) expCat = 8;
      else if (p < topP) begin expCat = 3; expPage = p; end
      else if (p >= 64'h10_0000 && p < baseP) begin expCat = 4; expPage = p; end
      else begin
        rel = p - topP + baseP;
        if (rel < limP) begin expCat = 5; expPage = rel; end
        else begin expCat = 6; expPage = (topP - 1) & MASK; expRange = 1; end
      end
      if (cfgWrEn) begin
        case (cfgSel)
          2'd0: mTop = cfgData;
          2'd1: mBase = cfgData;
          2'd2: mLimit = cfgData;
          default: ;
        endcase
      end
    end
  end

  function automatic string tagOf(int c);
    case (c)
      1: return "R1";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      default: return "R8";
    endcase
  endfunction

  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (outValid !== expValid) begin
        fails++;
        $display("FAIL R7 outValid actual=%0b expected=%0b", outValid, expValid);
      end
      checks++;
      if (outRange !== expRange) begin
        fails++;
        $display("FAIL %s outRange actual=%0b expected=%0b", tagOf(expCat), outRange, expRange);
      end
      checks++;
      if (longint'(outPage) !== expPage) begin
        fails++;
        $display("FAIL %s outPage actual=%h expected=%h", tagOf(expCat), outPage, expPage[31:0]);
      end
    end
  end

  task automatic cfgWrite(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgData = d; inValid = 1'b0;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic send(input logic [31:0] p);
    @(negedge clk);
    inValid = 1'b1; inPage = p; cfgWrEn = 1'b0;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic layout(input logic [15:0] t, input logic [15:0] b, input logic [15:0] l);
    cfgWrite(2'd0, t);
    cfgWrite(2'd1, b);
    cfgWrite(2'd2, l);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: zero layout, everything falls back to 0xFFFFFFFF
    send(32'h0);
    send(32'h1234);
    // layout A: base at the 4 GiB line
    layout(16'hC000, 16'h0040, 16'h0050);
    send(32'h1000);     // R3
    send(32'hBFFFF);    // R3 edge
    send(32'hC0000);    // R5
    send(32'hFFFFF);    // R5 limit-1
    send(32'h100000);   // R6 exact limit
    // layout B: base above the line, high gap exists
    layout(16'hC000, 16'h0080, 16'h00A0);
    send(32'h100000);   // R4
    send(32'h1FFFFF);   // R4 edge
    send(32'h200000);   // R6
    send(32'hC0000);    // R5
    // R2: select 3 ignored
    cfgWrite(2'd3, 16'h0001);
    send(32'hBFFFF);
    // R2: write in same cycle as a page uses the old value
    @(negedge clk);
    inValid = 1'b1; inPage = 32'hC0000; cfgWrEn = 1'b1; cfgSel = 2'd0; cfgData = 16'hD000;
    @(negedge clk);
    inValid = 1'b1; inPage = 32'hC0000; cfgWrEn = 1'b0;
    @(negedge clk);
    inValid = 1'b0;
    // top zero, largest base
    layout(16'h0000, 16'hFFFF, 16'hFFFF);
    send(32'h5);
    send(32'hFFFF_FFFF);
    send(32'h100000);
    // random phase
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      cfgWrEn = ($urandom % 8) == 0;
      cfgSel  = 2'($urandom % 4);
      cfgData = 16'($urandom);
      inValid = ($urandom % 4) != 0;
      case ($urandom % 3)
        0: inPage = 32'($urandom % 32'h40_0000);
        1: inPage = 32'($urandom % 32'h1_0000) + {cfgData, 14'd0};
        default: inPage = $urandom;
      endcase
    end
    @(negedge clk);
    inValid = 1'b0; cfgWrEn = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule